// File: doc/BRIEF.md
# Per-Channel Runtime Phase Parameter Fetch Engine

This block holds a table of 16-bit phase parameters for each of eight control channels and hands them out one at a time while an experiment runs. Before a run, a host fills the tables through a single write port. It also programs three small per-channel settings: how many parameters one circuit uses, how many shots each circuit is repeated for, and how many circuits the run contains. A start pulse then rewinds every channel to its first parameter.

During the run, each channel has its own request lane. This lane is shared with other users of the function-processor path. A request is served only when it carries the fetch function code and this engine's core identifier. The engine keeps the address itself: every accepted request returns the next word of the current circuit. At the end of a shot, the engine replays the same circuit's words. After the last shot of a circuit, it moves on to the next circuit's words. The answer comes back a fixed two cycles after the request. Once a channel has served its whole run, it raises a done flag. Any further fetch on that channel returns zero and latches an error flag.

Top module: `phase_fetch_engine`

## Requirements
- R1: A host write stores hostWrData in the bank selected by hostAddr[12:10], at word hostAddr[9:0]. No other bank changes. A write and a fetch on the same bank in the same cycle return the word held before the write.
- R2: A request is served only when reqFunc equals 10 and reqCore equals the CORE_ID parameter (default 3). Any other request produces no response and does not move the channel's position.
- R3: A request presented in cycle n produces rspValid for exactly one cycle, in cycle n+2, on the same channel lane.
- R4: Within one shot, successive fetches return consecutive words, starting at the circuit's base word.
- R5: After the last parameter of a shot that is not the circuit's last shot, the next fetch returns the circuit's base word again.
- R6: After the last shot of a circuit, the next fetch returns the word at the old base plus parameters-per-circuit.
- R7: done for a channel is low until its final parameter of its final shot of its final circuit has been accepted. It is high from the following cycle until the next start pulse.
- R8: A fetch accepted while done is high returns data 0 and sets that channel's err. err then stays high until start.
- R9: A start pulse clears done and err and rewinds every channel to word 0 of circuit 0, shot 0.
- R10: Requests on different channels in the same cycle are all served, each with its own data and the R3 latency. Back-to-back requests on one channel are served every cycle.
- R11: A configuration write to channel cfgCh sets parameters-per-circuit (cfgSel 0), shots-per-circuit (cfgSel 1) or circuit count (cfgSel 2) to cfgData. Each of these settings is 1 after reset.
- R12: During and right after reset, rspValid, done and err are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run start pulse, rewinds all channels |
| hostWrEn | input | 1 | Host table write strobe |
| hostAddr | input | 13 | Bank (upper 3 bits) and word (lower 10 bits) |
| hostWrData | input | 16 | Phase word to store |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgCh | input | 3 | Channel being configured |
| cfgSel | input | 2 | Setting selector: 0 params, 1 shots, 2 circuits |
| cfgData | input | 16 | Setting value |
| reqValid | input | 8 | Per-channel request valid |
| reqFunc | input | 8x4 | Per-channel function code |
| reqCore | input | 8x4 | Per-channel core identifier |
| rspValid | output | 8 | Per-channel response valid |
| rspData | output | 8x16 | Per-channel returned phase word |
| done | output | 8 | Per-channel run finished |
| err | output | 8 | Per-channel sticky over-fetch error |

## Verification
Two channels' fetches can land in the same cycle. So can a host table write and a fetch that reads the bank being written. The bench issues simultaneous requests on two channels for several consecutive cycles. It expects each lane's own sequence, with both answers in the same response cycle. Separately, it writes a word of one bank in the very cycle that channel fetches from that bank. The current fetch must return the old data. Some fetches later, the channel reaches the written word and must return the new value.

// File: rtl/pfe_pkg.sv
package pfe_pkg;

  // Strobes from a channel's control to its datapath
  typedef struct packed {
    logic rdEn;     // read the bank at rdAddr and answer with it
    logic zeroOut;  // answer with zero (channel already exhausted)
  } fetchStrobe_t;

  typedef enum logic [1:0] {
    CFG_PPC   = 2'd0,
    CFG_SPC   = 2'd1,
    CFG_NCIRC = 2'd2
  } cfgSel_e;

endpackage

// File: rtl/pfe_chan_ctrl.sv
module pfe_chan_ctrl
  import pfe_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int CNT_W      = 16,
  parameter int FUNC_W     = 4,
  parameter int CORE_W     = 4,
  parameter int FETCH_FUNC = 10,
  parameter int CORE_ID    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              cfgHit,
  input  logic [1:0]        cfgSel,
  input  logic [CNT_W-1:0]  cfgData,
  input  logic              reqValid,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [CORE_W-1:0] reqCore,
  output fetchStrobe_t      strobe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              done,
  output logic              err
);

  logic [CNT_W-1:0]  ppc, spc, ncirc;
  logic [CNT_W-1:0]  paramIdx, shotCnt, circIdx;
  logic [ADDR_W-1:0] base;
  logic accept, lastParam, lastShot, lastCirc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ppc   <= CNT_W'(1);
      spc   <= CNT_W'(1);
      ncirc <= CNT_W'(1);
    end else if (cfgHit) begin
      if (cfgSel == CFG_PPC)   ppc   <= cfgData;
      if (cfgSel == CFG_SPC)   spc   <= cfgData;
      if (cfgSel == CFG_NCIRC) ncirc <= cfgData;
    end
  end

  assign accept    = reqValid && (reqFunc == FUNC_W'(FETCH_FUNC)) && (reqCore == CORE_W'(CORE_ID));
  assign lastParam = (paramIdx == ppc - CNT_W'(1));
  assign lastShot  = (shotCnt == spc - CNT_W'(1));
  assign lastCirc  = (circIdx == ncirc - CNT_W'(1));
  assign rdAddr    = base + ADDR_W'(paramIdx);

  always_comb begin
    strobe.rdEn    = accept && !done;
    strobe.zeroOut = accept && done;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      paramIdx <= '0;
      shotCnt  <= '0;
      circIdx  <= '0;
      base     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else if (start) begin
      paramIdx <= '0;
      shotCnt  <= '0;
      circIdx  <= '0;
      base     <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else if (accept) begin
      if (done) begin
        err <= 1'b1;
      end else if (!lastParam) begin
        paramIdx <= paramIdx + CNT_W'(1);
      end else begin
        paramIdx <= '0;
        if (!lastShot) begin
          shotCnt <= shotCnt + CNT_W'(1);
        end else begin
          shotCnt <= '0;
          base    <= base + ADDR_W'(ppc);
          circIdx <= circIdx + CNT_W'(1);
          if (lastCirc) done <= 1'b1;
        end
      end
    end
  end

  // R7: done holds until the next start
  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // R8: error flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (err && !start) |=> err);

  // R9: start clears both flags
  a_r9_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (!done && !err));

endmodule

// File: rtl/pfe_chan_dp.sv
module pfe_chan_dp
  import pfe_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int DEPTH   = 1024,
  parameter int BANK_W  = 3,
  parameter int BANK    = 0,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int HADDR_W = BANK_W + ADDR_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               hostWrEn,
  input  logic [HADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0]  hostWrData,
  input  fetchStrobe_t       strobe,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic               rspValid,
  output logic [DATA_W-1:0]  rspData
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdQ;
  logic pendV, pendZ, bankHit;

  assign bankHit = hostWrEn && (hostAddr[HADDR_W-1 -: BANK_W] == BANK_W'(BANK));

  // Two-port bank: host write port, fetch read port (old data on collision)
  always_ff @(posedge clk) begin
    if (bankHit) mem[hostAddr[ADDR_W-1:0]] <= hostWrData;
    if (strobe.rdEn) rdQ <= mem[rdAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendV    <= 1'b0;
      pendZ    <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      pendV    <= strobe.rdEn || strobe.zeroOut;
      pendZ    <= strobe.zeroOut;
      rspValid <= pendV;
      rspData  <= pendZ ? '0 : rdQ;
    end
  end

  // R3: every served request answers exactly two cycles later
  a_r3_two_cycle: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdEn || strobe.zeroOut) |-> ##2 rspValid);

  // R3: no answer without a request two cycles earlier
  a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.rdEn && !strobe.zeroOut) |-> ##2 !rspValid);

  // R8: an exhausted channel answers zero
  a_r8_zero_data: assert property (@(posedge clk) disable iff (!rstN)
    strobe.zeroOut |-> ##2 (rspData == '0));

endmodule

// File: rtl/phase_fetch_engine.sv
module phase_fetch_engine
  import pfe_pkg::*;
#(
  parameter int NUM_CH     = 8,
  parameter int DATA_W     = 16,
  parameter int DEPTH      = 1024,
  parameter int CNT_W      = 16,
  parameter int FUNC_W     = 4,
  parameter int CORE_W     = 4,
  parameter int FETCH_FUNC = 10,
  parameter int CORE_ID    = 3,
  localparam int CH_W    = $clog2(NUM_CH),
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int HADDR_W = CH_W + ADDR_W
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           start,
  input  logic                           hostWrEn,
  input  logic [HADDR_W-1:0]             hostAddr,
  input  logic [DATA_W-1:0]              hostWrData,
  input  logic                           cfgWrEn,
  input  logic [CH_W-1:0]                cfgCh,
  input  logic [1:0]                     cfgSel,
  input  logic [CNT_W-1:0]               cfgData,
  input  logic [NUM_CH-1:0]              reqValid,
  input  logic [NUM_CH-1:0][FUNC_W-1:0]  reqFunc,
  input  logic [NUM_CH-1:0][CORE_W-1:0]  reqCore,
  output logic [NUM_CH-1:0]              rspValid,
  output logic [NUM_CH-1:0][DATA_W-1:0]  rspData,
  output logic [NUM_CH-1:0]              done,
  output logic [NUM_CH-1:0]              err
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    fetchStrobe_t      strobe;
    logic [ADDR_W-1:0] rdAddr;
    logic              cfgHit;

    assign cfgHit = cfgWrEn && (cfgCh == CH_W'(g));

    pfe_chan_ctrl #(
      .ADDR_W(ADDR_W), .CNT_W(CNT_W), .FUNC_W(FUNC_W), .CORE_W(CORE_W),
      .FETCH_FUNC(FETCH_FUNC), .CORE_ID(CORE_ID)
    ) u_ctrl (
      .clk(clk), .rstN(rstN), .start(start),
      .cfgHit(cfgHit), .cfgSel(cfgSel), .cfgData(cfgData),
      .reqValid(reqValid[g]), .reqFunc(reqFunc[g]), .reqCore(reqCore[g]),
      .strobe(strobe), .rdAddr(rdAddr), .done(done[g]), .err(err[g])
    );

    pfe_chan_dp #(
      .DATA_W(DATA_W), .DEPTH(DEPTH), .BANK_W(CH_W), .BANK(g)
    ) u_dp (
      .clk(clk), .rstN(rstN),
      .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
      .strobe(strobe), .rdAddr(rdAddr),
      .rspValid(rspValid[g]), .rspData(rspData[g])
    );
  end

endmodule

// File: tb/phase_fetch_engine_bench.sv
`timescale 1ns/1ps
module phase_fetch_engine_bench;
  localparam int NCH = 8;
  localparam int IMGW = 64;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, start, hostWrEn, cfgWrEn;
  logic [12:0] hostAddr;
  logic [15:0] hostWrData, cfgData;
  logic [2:0]  cfgCh;
  logic [1:0]  cfgSel;
  logic [NCH-1:0] reqValid;
  logic [NCH-1:0][3:0] reqFunc, reqCore;
  logic [NCH-1:0] rspValid, done, err;
  logic [NCH-1:0][15:0] rspData;

  phase_fetch_engine u_phase_fetch_engine (
    .clk(clk), .rstN(rstN), .start(start),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .cfgWrEn(cfgWrEn), .cfgCh(cfgCh), .cfgSel(cfgSel), .cfgData(cfgData),
    .reqValid(reqValid), .reqFunc(reqFunc), .reqCore(reqCore),
    .rspValid(rspValid), .rspData(rspData), .done(done), .err(err)
  );

  int vecCnt = 0, failCnt = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard queues
  int qCh[$];
  int qDue[$];
  logic [15:0] qData[$];
  string qTag[$];

  // reference model
  logic [15:0] img [NCH][IMGW];
  int mPpc[NCH], mSpc[NCH], mNc[NCH], mP[NCH], mS[NCH], mC[NCH];
  bit mDone[NCH];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    vecCnt++;
    if (act !== expv) begin
      failCnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // monitor: pop and compare as responses appear
  always @(negedge clk) begin
    if (rstN) begin
      for (int ch = 0; ch < NCH; ch++) begin
        if (rspValid[ch]) begin
          vecCnt++;
          if (qCh.size() == 0) begin
            failCnt++;
            $display("FAIL R2/R3: unexpected response ch%0d actual %0h expected none", ch, rspData[ch]);
          end else begin
            int ec, ed; logic [15:0] ev; string et;
            ec = qCh.pop_front(); ed = qDue.pop_front();
            ev = qData.pop_front(); et = qTag.pop_front();
            if (ec != ch || ed != cyc || rspData[ch] !== ev) begin
              failCnt++;
              $display("FAIL %s: actual ch%0d cyc%0d data %0h expected ch%0d cyc%0d data %0h",
                       et, ch, cyc, rspData[ch], ec, ed, ev);
            end
          end
        end
      end
    end
  end

  task automatic modelStart();
    for (int ch = 0; ch < NCH; ch++) begin
      mP[ch] = 0; mS[ch] = 0; mC[ch] = 0; mDone[ch] = 0;
    end
  endtask

  // driver: one request cycle on the channels in mask
  task automatic fetch(input logic [NCH-1:0] mask, input string tag);
    for (int ch = 0; ch < NCH; ch++) begin
      if (mask[ch]) begin
        reqValid[ch] = 1'b1; reqFunc[ch] = 4'd10; reqCore[ch] = 4'd3;
        qCh.push_back(ch); qDue.push_back(cyc + 2); qTag.push_back(tag);
        if (mDone[ch]) qData.push_back(16'h0);
        else begin
          qData.push_back(img[ch][mC[ch] * mPpc[ch] + mP[ch]]);
          if (mP[ch] == mPpc[ch] - 1) begin
            mP[ch] = 0;
            if (mS[ch] == mSpc[ch] - 1) begin
              mS[ch] = 0; mC[ch]++;
              if (mC[ch] == mNc[ch]) mDone[ch] = 1;
            end else mS[ch]++;
          end else mP[ch]++;
        end
      end
    end
    @(negedge clk);
    reqValid = '0;
  endtask

  task automatic rawReq(input int ch, input logic [3:0] f, input logic [3:0] c);
    reqValid[ch] = 1'b1; reqFunc[ch] = f; reqCore[ch] = c;
    @(negedge clk);
    reqValid = '0;
  endtask

  task automatic hostWr(input int bank, input int word, input logic [15:0] d);
    hostWrEn = 1'b1; hostAddr = 13'((bank << 10) | word); hostWrData = d;
    if (word < IMGW) img[bank][word] = d;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic cfgWr(input int ch, input int ppc, input int spc, input int nc);
    cfgWrEn = 1'b1; cfgCh = 3'(ch);
    cfgSel = 2'd0; cfgData = 16'(ppc); @(negedge clk);
    cfgSel = 2'd1; cfgData = 16'(spc); @(negedge clk);
    cfgSel = 2'd2; cfgData = 16'(nc);  @(negedge clk);
    cfgWrEn = 1'b0;
    mPpc[ch] = ppc; mSpc[ch] = spc; mNc[ch] = nc;
  endtask

  task automatic pulseStart();
    start = 1'b1; @(negedge clk); start = 1'b0;
    modelStart();
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, failCnt);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; start = 1'b0; hostWrEn = 1'b0; cfgWrEn = 1'b0;
    hostAddr = '0; hostWrData = '0; cfgCh = '0; cfgSel = '0; cfgData = '0;
    reqValid = '0; reqFunc = '0; reqCore = '0;
    for (int ch = 0; ch < NCH; ch++) begin
      mPpc[ch] = 1; mSpc[ch] = 1; mNc[ch] = 1;
    end
    modelStart();
    idle(3);
    // R12: reset state
    chk("R12 rspValid", 32'(rspValid), 0);
    chk("R12 done", 32'(done), 0);
    chk("R12 err", 32'(err), 0);
    rstN = 1'b1;
    idle(1);

    // R1: fill every bank with values that name bank and word
    for (int b = 0; b < NCH; b++)
      for (int w = 0; w < IMGW; w++)
        hostWr(b, w, 16'(16'h8000 | (b << 12) | w));

    // R11: configuration of several channels
    cfgWr(0, 3, 2, 2);
    cfgWr(1, 2, 1, 3);
    cfgWr(2, 4, 3, 1);
    cfgWr(4, 32, 1, 1);
    pulseStart();

    // R4 R5 R6: ch0 shot replay and circuit advance
    for (int i = 0; i < 11; i++) fetch(8'h01, "R4/R5/R6 ch0 sequence");
    chk("R7 done low before last", 32'(done[0]), 0);
    fetch(8'h01, "R6 ch0 last");
    chk("R7 done after last", 32'(done[0]), 1);
    chk("R8 err low before overfetch", 32'(err[0]), 0);
    fetch(8'h01, "R8 overfetch zero");
    chk("R8 err set", 32'(err[0]), 1);
    idle(2);
    chk("R8 err sticky", 32'(err[0]), 1);

    // R10: two channels every cycle, back to back
    for (int i = 0; i < 6; i++) fetch(8'h06, "R10 ch1+ch2 simultaneous");
    idle(1);
    chk("R10 ch1 done", 32'(done[1]), 1);
    chk("R10 ch2 not done", 32'(done[2]), 0);

    // R2: foreign function code and foreign core id are ignored
    rawReq(3, 4'd5, 4'd3);
    rawReq(3, 4'd10, 4'd4);
    idle(4);
    chk("R2 no response queued", 32'(qCh.size()), 0);
    chk("R2 done untouched", 32'(done[3]), 0);
    fetch(8'h08, "R2 position unchanged");

    // R11: default settings of 1 on ch7
    fetch(8'h80, "R11 default first word");
    idle(1);
    chk("R11 default done", 32'(done[7]), 1);
    fetch(8'h80, "R8 ch7 overfetch zero");
    chk("R8 ch7 err", 32'(err[7]), 1);

    // R1: rewrite bank 6 word 0, bank 5 untouched
    hostWr(6, 0, 16'h1234);
    pulseStart();
    // R9: flags cleared, counters rewound
    chk("R9 done cleared", 32'(done), 0);
    chk("R9 err cleared", 32'(err), 0);
    fetch(8'h01, "R9 ch0 rewound");
    fetch(8'h40, "R1 ch6 new word");
    fetch(8'h20, "R1 ch5 untouched");

    // R1: write to bank 4 word 20 in the same cycle ch4 reads word 0
    hostWrEn = 1'b1; hostAddr = 13'((4 << 10) | 20); hostWrData = 16'hBEEF;
    fetch(8'h10, "R1 collision returns old word");
    hostWrEn = 1'b0;
    img[4][20] = 16'hBEEF;
    for (int i = 0; i < 20; i++) fetch(8'h10, "R1 ch4 reaches written word");

    idle(4);
    chk("R3 all responses arrived", 32'(qCh.size()), 0);
    summary();
    $finish;
  end
endmodule